// File: doc/BRIEF.md
# Serial Programming Entry Key Detector

This block decides whether a device may leave normal operation and enter a serial program/verify mode. It watches three pins: an enable pin that doubles as the reset line, a programming clock and a programming data line. An attempt starts when the enable pin is pulsed high and driven low again. After a guard delay, a 32-bit unlock word is shifted in on the data line, one bit per rising edge of the programming clock, most significant bit first. The enable pin must then be raised within a bounded window and held high for as long as the mode is to be kept.

All pins pass through two-flop synchronizers, and all intervals are counted in system-clock cycles set by parameters. When the unlock word matches exactly, the key count is exactly 32 and the enable pin rises inside the window, the block raises a program-mode flag and a request to float the unused I/Os. A data-valid gate follows only after a hold-off. The hold-off is the larger of the window length and five programming-clock periods. Dropping the enable pin at any time ends the mode.

Top module: `prog_entry_detector`

## Requirements
- R1: While `rst_n` is low and right after reset, `prog_mode`, `data_valid` and `io_tristate` are all 0.
- R2: An attempt starts with a rise and then a fall of `en_pin`. While `en_pin` stays low, each rising edge of `sclk_pin` shifts the level of `sdat_pin` into the key, most significant bit (bit 31) first.
- R3: Entry happens only if the 32 shifted bits equal 0x4D434851. A word that differs in any single bit position leaves all outputs at 0.
- R4: Entry requires exactly 32 clock edges before `en_pin` rises. With 31 or 33 edges, all outputs stay 0.
- R5: Rising edges of `sclk_pin` during the first `P18_CYC` system cycles after the fall of `en_pin` are ignored and neither shift nor count.
- R6: `en_pin` must rise within `P19_CYC` system cycles after the 32nd key bit. A later rise leaves all outputs at 0 and returns the block to idle.
- R7: On a valid entry, `prog_mode` goes to 1 in the third system cycle after `en_pin` rises, which is the synchronizer latency plus one register.
- R8: `data_valid` goes to 1 exactly HOLD_CYC = max(`P19_CYC`, 5·`SCLK_CYC`) cycles after `prog_mode`. It stays 0 during that hold-off, whatever the clock and data lines do.
- R9: `io_tristate` is 1 exactly when `prog_mode` is 1, and `data_valid` is never 1 without it.
- R10: When `en_pin` goes low in program mode, all outputs return to 0 in the third cycle after the change. Raising `en_pin` again without a new key sequence does not re-enter the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | Reset/programming-enable pin (asynchronous) |
| sclk_pin | input | 1 | Programming clock pin (asynchronous) |
| sdat_pin | input | 1 | Programming data pin (asynchronous) |
| prog_mode | output | 1 | Program/verify mode is active |
| data_valid | output | 1 | Serial data may be interpreted (hold-off has elapsed) |
| io_tristate | output | 1 | Request to float all unused I/Os |

## Verification
Every pin change needs two synchronizer cycles plus one state register. A change driven at a falling clock edge therefore appears at the outputs at the third falling edge after it. The bench samples `prog_mode` at the second and third falling edges to pin that latency exactly. It checks `data_valid` at falling edges HOLD_CYC+2 and HOLD_CYC+3, toggling the programming clock throughout the hold-off. Rejection cases, which include a sweep flipping each of the 32 key bits, wrong counts, a late window and early guard edges, are judged well after the latency has passed, so no result hangs on a single edge.

// File: rtl/pe_pkg.sv
package pe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_GUARD,
        ST_SHIFT,
        ST_HOLD,
        ST_PROG
    } pe_state_t;

    localparam int unsigned PE_KEY_W = 32;
    localparam logic [PE_KEY_W-1:0] PE_UNLOCK_KEY = 32'h4D434851;

    function automatic int unsigned pe_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pe_sync.sv
module pe_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_in[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_out[i] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/pe_key_shift.sv
module pe_key_shift
    import pe_pkg::*;
#(
    parameter int unsigned             KEY_W = PE_KEY_W,
    parameter logic [KEY_W-1:0]        KEY   = PE_UNLOCK_KEY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift_en,
    input  logic din,
    output logic cnt_full,
    output logic cnt_over,
    output logic key_hit
);

    localparam int unsigned CW = $clog2(KEY_W + 2);
    localparam logic [CW-1:0] C_FULL = CW'(KEY_W);
    localparam logic [CW-1:0] C_OVER = CW'(KEY_W + 1);

    typedef struct packed {
        logic [KEY_W-1:0] shreg;
        logic [CW-1:0]    cnt;
    } ks_t;

    ks_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.shreg = '0;
            s_d.cnt   = '0;
        end else if (shift_en) begin
            // MSB arrives first, so older bits move up
            s_d.shreg = {s_q.shreg[KEY_W-2:0], din};
            if (s_q.cnt != C_OVER) s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_full = (s_q.cnt == C_FULL);
    assign cnt_over = (s_q.cnt == C_OVER);
    assign key_hit  = cnt_full && (s_q.shreg == KEY);

    // R4: the bit counter saturates one past the key length
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= C_OVER);

    // R10: a cleared shifter starts the next attempt from zero bits
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!cnt_full && !cnt_over && !key_hit));

endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
    import pe_pkg::*;
#(
    parameter int unsigned P18_CYC  = 16,
    parameter int unsigned P19_CYC  = 64,
    parameter int unsigned HOLD_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_lvl,
    input  logic sclk_lvl,
    input  logic cnt_full,
    input  logic cnt_over,
    input  logic key_hit,
    output logic shift_en,
    output logic shift_clear,
    output logic prog_mode,
    output logic data_valid,
    output logic io_tristate
);

    localparam int unsigned TMAX = pe_max(P18_CYC, HOLD_CYC);
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] T_P18  = TW'(P18_CYC);
    localparam logic [TW-1:0] T_P19  = TW'(P19_CYC);
    localparam logic [TW-1:0] T_HOLD = TW'(HOLD_CYC - 1);

    typedef struct packed {
        pe_state_t     state;
        logic [TW-1:0] timer;
        logic          en_prev;
        logic          sclk_prev;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic en_rise, sclk_rise;

    always_comb begin
        en_rise   = en_lvl & ~c_q.en_prev;
        sclk_rise = sclk_lvl & ~c_q.sclk_prev;

        c_d           = c_q;
        c_d.en_prev   = en_lvl;
        c_d.sclk_prev = sclk_lvl;

        case (c_q.state)
            ST_IDLE: begin
                c_d.timer = '0;
                if (en_rise) c_d.state = ST_PULSE;
            end
            ST_PULSE: begin
                c_d.timer = '0;
                if (!en_lvl) c_d.state = ST_GUARD;
            end
            ST_GUARD: begin
                if (en_rise) begin
                    c_d.state = ST_PULSE;
                    c_d.timer = '0;
                end else if (c_q.timer == T_P18) begin
                    c_d.state = ST_SHIFT;
                    c_d.timer = '0;
                end else begin
                    c_d.timer = c_q.timer + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (en_rise) begin
                    c_d.timer = '0;
                    if (key_hit && !cnt_over && (c_q.timer < T_P19))
                        c_d.state = ST_HOLD;
                    else
                        c_d.state = ST_IDLE;
                end else if (cnt_full) begin
                    // window timer runs from the last key bit, saturating
                    if (c_q.timer != T_P19) c_d.timer = c_q.timer + 1'b1;
                end else begin
                    c_d.timer = '0;
                end
            end
            ST_HOLD: begin
                if (!en_lvl) begin
                    c_d.state = ST_IDLE;
                    c_d.timer = '0;
                end else if (c_q.timer == T_HOLD) begin
                    c_d.state = ST_PROG;
                    c_d.timer = '0;
                end else begin
                    c_d.timer = c_q.timer + 1'b1;
                end
            end
            ST_PROG: begin
                c_d.timer = '0;
                if (!en_lvl) c_d.state = ST_IDLE;
            end
            default: begin
                c_d.state = ST_IDLE;
                c_d.timer = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state     <= ST_IDLE;
            c_q.timer     <= '0;
            c_q.en_prev   <= 1'b0;
            c_q.sclk_prev <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign shift_en    = (c_q.state == ST_SHIFT) && sclk_rise && !en_lvl;
    assign shift_clear = (c_q.state != ST_SHIFT);
    assign prog_mode   = (c_q.state == ST_HOLD) || (c_q.state == ST_PROG);
    assign io_tristate = prog_mode;
    assign data_valid  = (c_q.state == ST_PROG);

    // R3: the mode only starts right after a full matching key
    a_r3_entry_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_mode) |-> $past(key_hit));

    // R6: the enabling rise fell inside the window
    a_r6_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_mode) |-> ($past(c_q.timer) < T_P19));

    // R8: data is only gated on once the mode has been running
    a_r8_valid_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> $past(prog_mode));

    // R9: valid data implies the I/Os are floated
    a_r9_valid_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> io_tristate);

    // R10: a low enable level ends the mode on the next cycle
    a_r10_exit_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode && !en_lvl) |=> !prog_mode);

endmodule

// File: rtl/prog_entry_detector.sv
module prog_entry_detector
    import pe_pkg::*;
#(
    parameter int unsigned P18_CYC     = 16,
    parameter int unsigned P19_CYC     = 64,
    parameter int unsigned SCLK_CYC    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_pin,
    input  logic sclk_pin,
    input  logic sdat_pin,
    output logic prog_mode,
    output logic data_valid,
    output logic io_tristate
);

    localparam int unsigned HOLD_CYC = pe_max(P19_CYC, 5 * SCLK_CYC);

    logic [2:0] pins_sync;
    logic       en_lvl, sclk_lvl, sdat_lvl;
    logic       shift_en, shift_clear;
    logic       cnt_full, cnt_over, key_hit;

    pe_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sdat_pin, sclk_pin, en_pin}),
        .sync_out (pins_sync)
    );

    assign en_lvl   = pins_sync[0];
    assign sclk_lvl = pins_sync[1];
    assign sdat_lvl = pins_sync[2];

    pe_key_shift #(
        .KEY_W (PE_KEY_W),
        .KEY   (PE_UNLOCK_KEY)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (shift_clear),
        .shift_en (shift_en),
        .din      (sdat_lvl),
        .cnt_full (cnt_full),
        .cnt_over (cnt_over),
        .key_hit  (key_hit)
    );

    pe_ctrl #(
        .P18_CYC  (P18_CYC),
        .P19_CYC  (P19_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_lvl      (en_lvl),
        .sclk_lvl    (sclk_lvl),
        .cnt_full    (cnt_full),
        .cnt_over    (cnt_over),
        .key_hit     (key_hit),
        .shift_en    (shift_en),
        .shift_clear (shift_clear),
        .prog_mode   (prog_mode),
        .data_valid  (data_valid),
        .io_tristate (io_tristate)
    );

endmodule

// File: tb/prog_entry_detector_bench.sv
`timescale 1ns/1ps
module prog_entry_detector_bench;

    localparam int unsigned P18  = 8;
    localparam int unsigned P19  = 40;
    localparam int unsigned SCLK = 10;
    localparam int unsigned HOLD = (P19 > 5 * SCLK) ? P19 : 5 * SCLK;
    localparam logic [31:0] KEY  = 32'h4D434851;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_pin = 1'b0, sclk_pin = 1'b0, sdat_pin = 1'b0;
    logic prog_mode, data_valid, io_tristate;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    prog_entry_detector #(
        .P18_CYC (P18), .P19_CYC (P19), .SCLK_CYC (SCLK), .SYNC_STAGES (2)
    ) u_prog_entry_detector (
        .clk (clk), .rst_n (rst_n), .en_pin (en_pin), .sclk_pin (sclk_pin),
        .sdat_pin (sdat_pin), .prog_mode (prog_mode), .data_valid (data_valid),
        .io_tristate (io_tristate)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic negs(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic outs_zero(input string tag);
        check({prog_mode, data_valid, io_tristate} == 3'b000, tag,
              {prog_mode, data_valid, io_tristate}, 0);
    endtask

    task automatic send_bit(input logic b);
        sdat_pin = b; negs(3);
        sclk_pin = 1'b1; negs(3);
        sclk_pin = 1'b0; negs(4);
    endtask

    // pulse the enable pin and wait out the guard delay
    task automatic start_attempt();
        en_pin = 1'b1; negs(5);
        en_pin = 1'b0; negs(P18 + 8);
    endtask

    task automatic send_key(input logic [31:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) send_bit(w[31 - (i % 32)]);
    endtask

    // after a rejected attempt, check outputs stay low, then drop enable
    task automatic expect_reject(input string tag);
        negs(HOLD + 10);
        outs_zero(tag);
        en_pin = 1'b0; negs(6);
    endtask

    initial begin
        negs(3);
        outs_zero("R1 during reset");
        rst_n = 1'b1;
        negs(3);
        outs_zero("R1 after reset");

        // R2 R7 R8 R9: valid entry with exact latencies
        start_attempt();
        send_key(KEY, 32);
        negs(5);
        en_pin = 1'b1;
        negs(2);
        check(prog_mode == 1'b0, "R7 mode not before 3rd cycle", prog_mode, 0);
        negs(1);
        check(prog_mode == 1'b1, "R7 mode at 3rd cycle", prog_mode, 1);
        check(io_tristate == 1'b1, "R9 tristate with mode", io_tristate, 1);
        begin
            int early = 0;
            for (int i = 4; i <= HOLD + 2; i++) begin
                sclk_pin = (i % 4) < 2;
                sdat_pin = (i % 3) == 0;
                @(negedge clk);
                if (data_valid) early++;
            end
            sclk_pin = 1'b0;
            check(early == 0, "R8 no data_valid during hold-off", early, 0);
        end
        negs(1);
        check(data_valid == 1'b1, "R8 data_valid after hold-off", data_valid, 1);
        check(io_tristate == prog_mode, "R9 tristate equals mode", io_tristate, prog_mode);

        // R10: exit on enable low, then re-raise without a key
        en_pin = 1'b0;
        negs(2);
        check(prog_mode == 1'b1, "R10 mode still set at 2nd cycle", prog_mode, 1);
        negs(1);
        outs_zero("R10 outputs clear at 3rd cycle");
        negs(4);
        en_pin = 1'b1;
        negs(HOLD + 10);
        outs_zero("R10 no re-entry without key");
        en_pin = 1'b0; negs(6);

        // R3: flip each bit of the key in turn
        for (int p = 0; p < 32; p++) begin
            start_attempt();
            send_key(KEY ^ (32'h1 << p), 32);
            negs(5);
            en_pin = 1'b1;
            expect_reject($sformatf("R3 key bit %0d flipped", p));
        end

        // R3: all-zero and all-one words
        start_attempt(); send_key(32'h0, 32); negs(5); en_pin = 1'b1;
        expect_reject("R3 all-zero word");
        start_attempt(); send_key(32'hFFFF_FFFF, 32); negs(5); en_pin = 1'b1;
        expect_reject("R3 all-one word");

        // R4: short and long counts
        start_attempt(); send_key(KEY, 31); negs(5); en_pin = 1'b1;
        expect_reject("R4 31 edges");
        start_attempt(); send_key(KEY, 32); send_bit(1'b1); negs(5); en_pin = 1'b1;
        expect_reject("R4 33 edges");

        // R6: enable rises after the window
        start_attempt(); send_key(KEY, 32); negs(P19 + 20); en_pin = 1'b1;
        expect_reject("R6 late enable rise");

        // R5: a clock edge inside the guard delay is ignored
        en_pin = 1'b1; negs(5);
        en_pin = 1'b0; negs(2);
        sdat_pin = 1'b1; sclk_pin = 1'b1; negs(2);
        sclk_pin = 1'b0; negs(P18 + 8);
        send_key(KEY, 32);
        negs(5);
        en_pin = 1'b1;
        negs(3);
        check(prog_mode == 1'b1, "R5 guard edge ignored, entry ok", prog_mode, 1);
        negs(HOLD + 2);
        check(data_valid == 1'b1, "R8 data_valid on second entry", data_valid, 1);
        en_pin = 1'b0;
        negs(3);
        outs_zero("R10 exit after second entry");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule